// File: doc/BRIEF.md
# BCD Digit Scanner with Centred Strobe

This block presents a five-digit decimal result on one shared four-bit BCD bus. It does this by time-multiplexing the digits. Each digit has its own active-high select line. The scan starts at the most significant digit and walks down to the least significant digit. A new-result event captures the digit vector and the overrange flag, and it starts a fresh scan from the most significant digit. The scan then repeats on its own, so a multiplexed display keeps refreshing.

After each new result, the first pass of the scan also gives an active-low strobe. The strobe falls once in the centre of each digit slot and lasts only the low half of that clock. A downstream latch or processor can use it to pick up each digit exactly once. Later passes carry no strobe.

When the captured result is overrange, the data lines read zero. After the fifth strobe the selects go dark until a reference-integrate-start pulse arrives, so the display blinks.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset, `sel_o` and `bcd_o` are all zero and `strobe_n_o` is high. Nothing scans until the first `result_i`. A `refint_i` pulse or a change on `digits_i` before that has no visible effect.
- R2: At most one select is high at a time. `sel_o[i]` selects digit i, where bit 4 is the most significant digit. The order is bit 4, 3, 2, 1, 0, and then it wraps back to bit 4.
- R3: Counting from the first cycle after the edge that sampled `result_i`, the most significant slot lasts 201 cycles. Every other slot lasts 200 cycles, including the most significant slot on later passes.
- R4: On the first pass after a result, `strobe_n_o` goes low in exactly one cycle per slot, at slot offset 100. The first one is therefore in cycle 100 after the result. Five strobes occur in total, and later passes have none.
- R5: A strobe is low only during the low phase of `clk_i` in its cycle. It is high during the high phase of that cycle.
- R6: `bcd_o` carries the selected digit, and bit 3 has weight 8. Digit i is taken from `digits_i[4*i+3:4*i]` as sampled at the `result_i` edge. The data changes in the same cycle as the select.
- R7: While the captured overrange flag is set, `bcd_o` is all zero.
- R8: With overrange set, every select goes low from the cycle after the fifth strobe (cycle 902) and stays low until `refint_i` is sampled. A `refint_i` pulse while scanning has no effect.
- R9: When `refint_i` ends blanking, scanning resumes at the most significant digit. Every slot is then 200 cycles long and there is no strobe.
- R10: A `result_i` pulse at any point, whether idle, mid-scan or blanked, restarts at the most significant digit on the next cycle. It arms the five strobes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also gates the half-cycle strobe |
| rst_i | input | 1 | Synchronous active-high reset |
| result_i | input | 1 | New-result event, one cycle |
| digits_i | input | 20 | Five BCD digits, digit 0 in bits 3:0 |
| overrange_i | input | 1 | Overrange flag of the new result |
| refint_i | input | 1 | Reference-integrate start, ends blanking |
| sel_o | output | 5 | One-hot digit selects, bit 4 is the most significant digit |
| bcd_o | output | 4 | Shared BCD data, bit 3 weight 8 |
| strobe_n_o | output | 1 | Active-low half-cycle strobe |

## Verification
On every cycle the assertions check four things: the selects stay one-hot-or-zero and only step downward with a wrap, a result always lands on the most significant select, the data is zero under overrange, and the selects stay dark while blanked. Slot widths of 201 and 200 cycles, the exact cycle of each strobe and its low-phase-only shape, and strobe suppression on later passes are all matters of counting. Only the bench's walks can show these, by comparing every cycle with a model. The same holds for digit capture and for a reference pulse being ignored mid-scan.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
    localparam int DEF_DIGITS = 5;
    localparam int DEF_BCD_W  = 4;
    localparam int DEF_SLOT   = 200;
    localparam int DEF_CENTRE = 100;

    typedef enum logic [1:0] {
        SCN_IDLE  = 2'd0,
        SCN_RUN   = 2'd1,
        SCN_BLANK = 2'd2
    } scan_state_e;
endpackage

// File: rtl/dsc_slot_timer.sv
`timescale 1ns/1ps
module dsc_slot_timer #(
    parameter int SLOT_CLKS = 200,
    parameter int CENTRE    = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic long_i,
    input  logic run_i,
    output logic mid_o,
    output logic end_o
);
    localparam int CNT_W = $clog2(SLOT_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SLOT_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(SLOT_CLKS);
    localparam logic [CNT_W-1:0] MID_POS    = CNT_W'(CENTRE);

    logic [CNT_W-1:0] cnt_q;
    logic             long_q;

    // The first slot after a result runs one extra cycle.
    assign end_o = (cnt_q == (long_q ? LAST_LONG : LAST_SHORT));
    assign mid_o = (cnt_q == MID_POS);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            long_q <= long_i;
        end else if (run_i) begin
            if (end_o) begin
                cnt_q  <= '0;
                long_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsc_sequencer.sv
`timescale 1ns/1ps
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int DIGITS = 5,
    parameter int BCD_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    result_i,
    input  logic [DIGITS*BCD_W-1:0] digits_i,
    input  logic                    ovr_i,
    input  logic                    refint_i,
    input  logic                    mid_i,
    input  logic                    end_i,
    output scan_state_e             state_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic                    armed_o,
    output logic                    ovr_o,
    output logic [DIGITS*BCD_W-1:0] digits_o,
    output logic                    load_o,
    output logic                    long_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

    scan_state_e             state_q;
    logic [IDX_W-1:0]        idx_q;
    logic                    armed_q;
    logic                    ovr_q;
    logic [DIGITS*BCD_W-1:0] digits_q;

    assign load_o   = result_i || (state_q == SCN_BLANK && refint_i);
    assign long_o   = result_i;
    assign state_o  = state_q;
    assign idx_o    = idx_q;
    assign armed_o  = armed_q;
    assign ovr_o    = ovr_q;
    assign digits_o = digits_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= SCN_IDLE;
            idx_q    <= '0;
            armed_q  <= 1'b0;
            ovr_q    <= 1'b0;
            digits_q <= '0;
        end else if (result_i) begin
            state_q  <= SCN_RUN;
            idx_q    <= LAST_IDX;
            armed_q  <= 1'b1;
            ovr_q    <= ovr_i;
            digits_q <= digits_i;
        end else begin
            case (state_q)
                SCN_RUN: begin
                    if (armed_q && idx_q == '0 && mid_i) begin
                        // Last strobe of the pass just issued.
                        armed_q <= 1'b0;
                        if (ovr_q) state_q <= SCN_BLANK;
                    end else if (end_i) begin
                        idx_q <= (idx_q == '0) ? LAST_IDX : idx_q - 1'b1;
                    end
                end
                SCN_BLANK: begin
                    if (refint_i) begin
                        state_q <= SCN_RUN;
                        idx_q   <= LAST_IDX;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/dsc_outputs.sv
`timescale 1ns/1ps
module dsc_outputs
    import dsc_pkg::*;
#(
    parameter int DIGITS = 5,
    parameter int BCD_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic                    clk_i,
    input  scan_state_e             state_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    armed_i,
    input  logic                    ovr_i,
    input  logic                    mid_i,
    input  logic [DIGITS*BCD_W-1:0] digits_i,
    output logic [DIGITS-1:0]       sel_o,
    output logic [BCD_W-1:0]        bcd_o,
    output logic                    strobe_act_o,
    output logic                    strobe_n_o
);
    logic             run;
    logic [BCD_W-1:0] dig_arr [DIGITS];

    assign run = (state_i == SCN_RUN);

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign sel_o[g]   = run && (idx_i == IDX_W'(g));
        assign dig_arr[g] = digits_i[g*BCD_W +: BCD_W];
    end

    assign bcd_o = (run && !ovr_i) ? dig_arr[idx_i] : '0;

    // Centre cycle of an armed slot; the low clock phase shapes the half pulse.
    assign strobe_act_o = run && armed_i && mid_i;
    assign strobe_n_o   = ~(strobe_act_o & ~clk_i);
endmodule

// File: rtl/bcd_digit_scanner.sv
`timescale 1ns/1ps
module bcd_digit_scanner
    import dsc_pkg::*;
#(
    parameter int NUM_DIGITS = DEF_DIGITS,
    parameter int BCD_W      = DEF_BCD_W,
    parameter int SLOT_CLKS  = DEF_SLOT,
    parameter int CENTRE     = DEF_CENTRE
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        result_i,
    input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
    input  logic                        overrange_i,
    input  logic                        refint_i,
    output logic [NUM_DIGITS-1:0]       sel_o,
    output logic [BCD_W-1:0]            bcd_o,
    output logic                        strobe_n_o
);
    localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    scan_state_e                 state_w;
    logic [IDX_W-1:0]            idx_w;
    logic                        armed_w;
    logic                        ovr_w;
    logic [NUM_DIGITS*BCD_W-1:0] held_w;
    logic                        load_w;
    logic                        long_w;
    logic                        mid_w;
    logic                        end_w;
    logic                        strobe_act_w;
    logic                        blank_w;

    assign blank_w = (state_w == SCN_BLANK);

    dsc_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .CENTRE    (CENTRE)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_w),
        .long_i (long_w),
        .run_i  (state_w == SCN_RUN),
        .mid_o  (mid_w),
        .end_o  (end_w)
    );

    dsc_sequencer #(
        .DIGITS (NUM_DIGITS),
        .BCD_W  (BCD_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .result_i (result_i),
        .digits_i (digits_i),
        .ovr_i    (overrange_i),
        .refint_i (refint_i),
        .mid_i    (mid_w),
        .end_i    (end_w),
        .state_o  (state_w),
        .idx_o    (idx_w),
        .armed_o  (armed_w),
        .ovr_o    (ovr_w),
        .digits_o (held_w),
        .load_o   (load_w),
        .long_o   (long_w)
    );

    dsc_outputs #(
        .DIGITS (NUM_DIGITS),
        .BCD_W  (BCD_W),
        .IDX_W  (IDX_W)
    ) u_out (
        .clk_i        (clk_i),
        .state_i      (state_w),
        .idx_i        (idx_w),
        .armed_i      (armed_w),
        .ovr_i        (ovr_w),
        .mid_i        (mid_w),
        .digits_i     (held_w),
        .sel_o        (sel_o),
        .bcd_o        (bcd_o),
        .strobe_act_o (strobe_act_w),
        .strobe_n_o   (strobe_n_o)
    );
endmodule

// File: rtl/dsc_checker.sv
`timescale 1ns/1ps
module dsc_checker #(
    parameter int DIGITS = 5,
    parameter int BCD_W  = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              result_i,
    input logic              refint_i,
    input logic [DIGITS-1:0] sel_i,
    input logic [BCD_W-1:0]  bcd_i,
    input logic              ovr_i,
    input logic              blank_i,
    input logic              strobe_act_i
);
    localparam logic [DIGITS-1:0] MSD_SEL = DIGITS'(1) << (DIGITS - 1);
    localparam logic [DIGITS-1:0] LSD_SEL = DIGITS'(1);

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(sel_i)) else $error("select not one-hot"); // R2

    AST_SEL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i != '0 && !result_i) |=>
        (sel_i == $past(sel_i) || sel_i == '0 ||
         sel_i == (($past(sel_i) == LSD_SEL) ? MSD_SEL : ($past(sel_i) >> 1))))
        else $error("select stepped out of order"); // R2

    AST_RESTART_MSD: assert property (@(posedge clk_i) disable iff (rst_i)
        result_i |=> (sel_i == MSD_SEL)) else $error("no restart at MSD"); // R10

    AST_OVR_BCD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_i |-> (bcd_i == '0)) else $error("data under overrange"); // R7

    AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (blank_i && !refint_i && !result_i) |=> (sel_i == '0))
        else $error("select during blanking"); // R8

    AST_STROBE_IN_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_act_i |-> (sel_i != '0)) else $error("strobe outside slot"); // R4
endmodule

bind bcd_digit_scanner dsc_checker #(
    .DIGITS (NUM_DIGITS),
    .BCD_W  (BCD_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .result_i     (result_i),
    .refint_i     (refint_i),
    .sel_i        (sel_o),
    .bcd_i        (bcd_o),
    .ovr_i        (ovr_w),
    .blank_i      (blank_w),
    .strobe_act_i (strobe_act_w)
);

// File: tb/bcd_digit_scanner_bench.sv
`timescale 1ns/1ps
module bcd_digit_scanner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res = 1'b0;
    logic [19:0] digs = '0;
    logic        ovr = 1'b0;
    logic        refint = 1'b0;
    logic [4:0]  sel;
    logic [3:0]  bcd;
    logic        strobe_n;

    int checks = 0;
    int errors = 0;

    // bit 20 = overrange, bits 19:0 = digits
    localparam logic [20:0] VEC [4] = '{21'h012345, 21'h009876, 21'h115555, 21'h000000};
    localparam int WALK = 1300;

    always #2.5 clk = ~clk;

    bcd_digit_scanner u_bcd_digit_scanner (
        .clk_i       (clk),
        .rst_i       (rst),
        .result_i    (res),
        .digits_i    (digs),
        .overrange_i (ovr),
        .refint_i    (refint),
        .sel_o       (sel),
        .bcd_o       (bcd),
        .strobe_n_o  (strobe_n)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Leaves the bench in the low phase of cycle 0 after the sampling edge.
    task automatic pulse_result(logic [19:0] d, logic o);
        @(negedge clk);
        digs = d; ovr = o; res = 1'b1;
        @(posedge clk);
        #1 res = 1'b0; digs = ~d; ovr = ~o;
        #2.75;
    endtask

    task automatic pulse_refint();
        @(negedge clk);
        refint = 1'b1;
        @(posedge clk);
        #1 refint = 1'b0;
        #2.75;
    endtask

    task automatic tick();
        @(posedge clk);
        #3.75;
    endtask

    function automatic int exp_idx(int k, bit o);
        if (o && k >= 902) return -1;
        if (k < 201) return 4;
        return 4 - ((1 + (k - 201) / 200) % 5);
    endfunction

    function automatic int slot_off(int k);
        return (k < 201) ? k : (k - 201) % 200;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #2.75;
        // R1: reset state, idle ignores refint and digit changes
        chk("R1", "sel after reset", 32'(sel), 32'h0);
        chk("R1", "bcd after reset", 32'(bcd), 32'h0);
        chk("R1", "strobe after reset", 32'(strobe_n), 32'h1);
        digs = 20'h98765;
        pulse_refint();
        tick();
        chk("R1", "sel idle after refint", 32'(sel), 32'h0);
        chk("R1", "bcd idle", 32'(bcd), 32'h0);

        // Table walk: every cycle against the model (R2 R3 R4 R6 R7 R8 R10)
        for (int v = 0; v < 4; v++) begin
            logic [19:0] d;
            bit          o;
            d = VEC[v][19:0];
            o = VEC[v][20];
            pulse_result(d, o);
            for (int k = 0; k < WALK; k++) begin
                int i;
                i = exp_idx(k, o);
                chk("R2 R3 R8", "sel", 32'(sel), (i < 0) ? 32'h0 : 32'(1 << i));
                chk("R6 R7", "bcd", 32'(bcd), (i < 0 || o) ? 32'h0 : 32'(d[4*i +: 4]));
                chk("R4", "strobe", 32'(strobe_n), (k < 1001 && slot_off(k) == 100) ? 32'h0 : 32'h1);
                if (k == 300) refint = 1'b1;   // R8: ignored while scanning
                if (k == 301) refint = 1'b0;
                tick();
            end
        end

        // R9: resume after overrange blanking
        pulse_result(20'h12345, 1'b1);
        for (int k = 0; k < 950; k++) tick();
        chk("R8", "sel blanked", 32'(sel), 32'h0);
        pulse_refint();
        for (int c = 0; c < 400; c++) begin
            chk("R9", "resume sel", 32'(sel), 32'(1 << (4 - (c / 200) % 5)));
            chk("R7", "resume bcd", 32'(bcd), 32'h0);
            chk("R9", "resume strobe", 32'(strobe_n), 32'h1);
            tick();
        end

        // R10: restart mid-scan with new digits; R5 half-clock strobe
        pulse_result(20'h24680, 1'b0);
        for (int k = 0; k < 450; k++) tick();
        chk("R10", "mid-scan sel", 32'(sel), 32'h04);
        pulse_result(20'h13579, 1'b0);
        chk("R10", "restart sel", 32'(sel), 32'h10);
        chk("R10", "restart bcd", 32'(bcd), 32'h1);
        for (int k = 0; k < 99; k++) tick();
        @(posedge clk);
        #1.25;
        chk("R5", "strobe high phase", 32'(strobe_n), 32'h1);
        #2.5;
        chk("R5", "strobe low phase", 32'(strobe_n), 32'h0);
        chk("R10", "strobe rearmed", 32'(sel), 32'h10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule